// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the two error counters of a CAN node and turns them into the node's fault confinement state: error active, error passive or bus-off. A bit-stream processor feeds it one-cycle event pulses (transmit error, receive error, successful transmission, successful reception, end of intermission), plus a sample-point strobe and the level sampled at that strobe. From these the block updates its counters, chooses the polarity of the error flag the node sends, asks for the suspend-transmission gap an error passive transmitter owes, and forces the transmit line recessive while the node is off the bus.

Software can overwrite the transmit error counter, but only while the node is held in reset mode. This lets it push the node straight into bus-off or error passive for test. Once reset mode is released, a bus-off node counts runs of eleven recessive sampled bits. After 128 such runs it clears both counters and goes back to error active.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters read 0, the state is error active (code 0), and bus_off, err_flag_passive and suspend_req are all 0.
- R2: Outside reset mode and bus-off, a transmit error pulse adds 8 to the transmit counter. A successful transmit pulse subtracts 1 from it, and the counter stays at 0 once there.
- R3: Outside reset mode and bus-off, a receive error pulse adds 1 to the receive counter, saturating at 255. A successful reception pulse subtracts 1, stopping at 0.
- R4: The state is error passive (code 1) when either counter is 128 or more and the node is not bus-off. Sixteen transmit errors from zero therefore move the node to passive, and fifteen do not.
- R5: A transmit error that would take the transmit counter to 256 or beyond sets the counter to 256. It asserts bus_off on the same clock edge and sets the state to bus-off (code 2). While bus_off is 1, tx_out is 1 whatever tx_in is.
- R6: A counter write takes effect only while reset_mode is 1 and is ignored otherwise. Writing 255 sets bus-off. Writing a value below 255 clears bus-off, so a value from 128 to 254 leaves the node error passive.
- R7: Event pulses leave both counters unchanged while reset_mode is 1 or while the node is bus-off.
- R8: Recovery counting runs only while bus-off with reset_mode at 0. After the 128th run of eleven consecutive recessive sampled bits, both counters are cleared on that clock edge and the state returns to error active.
- R9: A dominant sampled bit during recovery restarts the current eleven-bit run but keeps the number of runs already completed.
- R10: err_flag_passive is 0 in error active, where the node flags errors with dominant bits, and 1 otherwise, where the flag is recessive.
- R11: When the intermission-end pulse arrives while the node is error passive and has transmitted in the current frame, suspend_req rises on that edge and stays high for exactly 8 sample points. If the node did not transmit, suspend_req stays low.
- R12: Once recovery is complete, tx_out follows tx_in again, so the node can transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_pt | input | 1 | One-cycle strobe at each bit's sample point |
| rx_bit | input | 1 | Bus level at the sample point (1 = recessive) |
| tx_err | input | 1 | Transmit error pulse |
| rx_err | input | 1 | Receive error pulse |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_ok | input | 1 | Successful reception pulse |
| ifs_end | input | 1 | End-of-intermission pulse |
| reset_mode | input | 1 | Node held in reset mode by software |
| tec_wr_en | input | 1 | Write strobe for the transmit error counter |
| tec_wr_data | input | 8 | Value to write |
| tx_in | input | 1 | Transmit bit from the bit-stream processor |
| tx_out | output | 1 | Transmit bit towards the bus, forced recessive in bus-off |
| fc_state | output | 2 | 0 error active, 1 error passive, 2 bus-off |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| err_flag_passive | output | 1 | Error flag polarity select (1 = recessive flag) |
| suspend_req | output | 1 | Suspend-transmission request |
| bus_off | output | 1 | Bus-off status |

## Verification
The counters are driven by a run of sixteen transmit errors, checked both at the fifteenth step (still active) and the sixteenth (passive). Interleaved receive errors and successes show saturation at zero. A further run pushes the transmit counter to the ceiling, which separates "255 still passive" from "overflow to bus-off". Recovery is tried with a stream of recessive bits that has a single dominant bit placed just before the last run would complete: a design that ignores the dominant bit finishes early, and one that drops completed runs never finishes. Counter writes are issued with and without reset mode, using the values 255 and 245, and a recovery is then run after reset mode is released, so write gating, forced bus-off and forced passive entry are each told apart.

// File: rtl/can_fc_pkg.sv
// Shared definitions for the CAN fault confinement block.
// Assumes: state codes are read by neighbouring logic as listed here.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_tx_counter.sv
// Transmit error counter: +STEP per error, -1 per success, software load.
// Assumes: wr_en arrives already gated by reset mode; clear has top priority.
module fc_tx_counter #(
    parameter int CNT_W = 9,
    parameter int STEP  = 8,
    parameter int LIMIT = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen,
    input  logic             clear,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             wr_en,
    input  logic [CNT_W-2:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             overflow
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_nxt;
    logic [SUM_W-1:0] sum;

    // Next-value selection: clear, load, error step, success step.
    always_comb begin
        cnt_nxt  = cnt;
        overflow = 1'b0;
        sum      = {1'b0, cnt} + SUM_W'(STEP);
        if (clear) begin
            cnt_nxt = '0;
        end else if (wr_en) begin
            cnt_nxt = {1'b0, wr_data};
        end else if (!frozen) begin
            if (tx_err) begin
                if (sum >= SUM_W'(LIMIT)) begin
                    cnt_nxt  = CNT_W'(LIMIT);
                    overflow = 1'b1;
                end else begin
                    cnt_nxt = sum[CNT_W-1:0];
                end
            end else if (tx_ok && cnt != '0) begin
                cnt_nxt = cnt - 1'b1;
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    p_tec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frozen && !clear && !wr_en && tx_err && cnt < CNT_W'(LIMIT - STEP))
        |=> cnt == $past(cnt) + CNT_W'(STEP));

    p_tec_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LIMIT));
endmodule

// File: rtl/fc_rx_counter.sv
// Receive error counter: +1 per error, -1 per success, saturating both ways.
// Assumes: frozen covers reset mode and bus-off.
module fc_rx_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen,
    input  logic             clear,
    input  logic             rx_err,
    input  logic             rx_ok,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Counter update with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (!frozen) begin
            if (rx_err) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end else if (rx_ok && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    p_rec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clear) |=> $stable(cnt));
endmodule

// File: rtl/fc_busoff_recovery.sv
// Counts runs of RUN_LEN recessive sampled bits while enabled; pulses done
// on the sample that completes run number RUN_TOTAL.
// Assumes: enable = bus-off and not reset mode; counts clear when disabled.
module fc_busoff_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_TOTAL = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sample,
    input  logic rx_bit,
    output logic done
);
    localparam int BIT_W = $clog2(RUN_LEN);
    localparam int RUN_W = $clog2(RUN_TOTAL);

    logic [BIT_W-1:0] bit_cnt;
    logic [RUN_W-1:0] runs;
    logic             run_end;

    assign run_end = enable && sample && rx_bit && bit_cnt == BIT_W'(RUN_LEN - 1);
    assign done    = run_end && runs == RUN_W'(RUN_TOTAL - 1);

    // Bit-in-run and completed-run counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bit_cnt <= '0;
            runs    <= '0;
        end else if (sample) begin
            if (!rx_bit) begin
                bit_cnt <= '0;
            end else if (run_end) begin
                bit_cnt <= '0;
                runs    <= done ? '0 : runs + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    p_runs_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample && !rx_bit) |=> $stable(runs));
endmodule

// File: rtl/fc_suspend.sv
// Suspend-transmission timer: an error passive node that transmitted in the
// frame requests SUSP_BITS sample points of suspension after intermission.
// Assumes: hold_clear is asserted in reset mode and bus-off.
module fc_suspend #(
    parameter int SUSP_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clear,
    input  logic passive,
    input  logic tx_event,
    input  logic ifs_end,
    input  logic sample,
    output logic suspend_req
);
    localparam int SC_W = $clog2(SUSP_BITS + 1);

    logic [SC_W-1:0] left;
    logic            was_tx;

    assign suspend_req = left != '0;

    // Transmitter memory and suspension countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) begin
            left   <= '0;
            was_tx <= 1'b0;
        end else if (ifs_end) begin
            was_tx <= 1'b0;
            if (passive && (was_tx || tx_event)) left <= SC_W'(SUSP_BITS);
        end else begin
            if (tx_event) was_tx <= 1'b1;
            if (sample && left != '0) left <= left - 1'b1;
        end
    end

    p_susp_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspend_req) |-> $past(ifs_end));
endmodule

// File: rtl/can_fault_confine.sv
// CAN fault confinement: holds both error counters, derives the node state,
// the error flag polarity, the suspend request and the bus-off transmit gate.
// Assumes: event inputs are single-cycle pulses from the bit-stream logic.
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int REC_W       = 8,
    parameter int TEC_STEP    = 8,
    parameter int PASSIVE_LIM = 128,
    parameter int RUN_LEN     = 11,
    parameter int RUN_TOTAL   = 128,
    parameter int SUSP_BITS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_pt,
    input  logic             rx_bit,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             ifs_end,
    input  logic             reset_mode,
    input  logic             tec_wr_en,
    input  logic [REC_W-1:0] tec_wr_data,
    input  logic             tx_in,
    output logic             tx_out,
    output logic [1:0]       fc_state,
    output logic [REC_W:0]   tec,
    output logic [REC_W-1:0] rec,
    output logic             err_flag_passive,
    output logic             suspend_req,
    output logic             bus_off
);
    localparam int TEC_W     = REC_W + 1;
    localparam int BOFF_LIM  = 2 ** REC_W;

    logic      frozen;
    logic      wr_ok;
    logic      tec_ovf;
    logic      recov_done;
    logic      passive;
    fc_state_e state;

    assign frozen = reset_mode || bus_off;
    assign wr_ok  = tec_wr_en && reset_mode;

    fc_tx_counter #(.CNT_W(TEC_W), .STEP(TEC_STEP), .LIMIT(BOFF_LIM)) u_tec (
        .clk(clk), .rst_n(rst_n), .frozen(frozen), .clear(recov_done),
        .tx_err(tx_err), .tx_ok(tx_ok), .wr_en(wr_ok), .wr_data(tec_wr_data),
        .cnt(tec), .overflow(tec_ovf)
    );

    fc_rx_counter #(.CNT_W(REC_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .frozen(frozen), .clear(recov_done),
        .rx_err(rx_err), .rx_ok(rx_ok), .cnt(rec)
    );

    fc_busoff_recovery #(.RUN_LEN(RUN_LEN), .RUN_TOTAL(RUN_TOTAL)) u_recov (
        .clk(clk), .rst_n(rst_n), .enable(bus_off && !reset_mode),
        .sample(sample_pt), .rx_bit(rx_bit), .done(recov_done)
    );

    // Bus-off flag: set by overflow or a forced write, cleared by recovery.
    always_ff @(posedge clk) begin
        if (!rst_n)          bus_off <= 1'b0;
        else if (recov_done) bus_off <= 1'b0;
        else if (wr_ok)      bus_off <= (tec_wr_data == '1);
        else if (tec_ovf)    bus_off <= 1'b1;
    end

    // State derivation from the bus-off flag and counter levels.
    always_comb begin
        if (bus_off)
            state = FC_BUSOFF;
        else if (tec >= TEC_W'(PASSIVE_LIM) || {1'b0, rec} >= TEC_W'(PASSIVE_LIM))
            state = FC_PASSIVE;
        else
            state = FC_ACTIVE;
    end

    assign passive          = state == FC_PASSIVE;
    assign fc_state         = state;
    assign err_flag_passive = state != FC_ACTIVE;
    assign tx_out           = tx_in || bus_off;

    fc_suspend #(.SUSP_BITS(SUSP_BITS)) u_susp (
        .clk(clk), .rst_n(rst_n), .hold_clear(frozen), .passive(passive),
        .tx_event(tx_err || tx_ok), .ifs_end(ifs_end), .sample(sample_pt),
        .suspend_req(suspend_req)
    );

    p_recov_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done |=> (tec == '0 && rec == '0 && !bus_off));

    p_wr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_wr_en && !reset_mode && !tx_err && !tx_ok && !recov_done)
        |=> $stable(tec));

    p_ovf_sets_boff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_ovf && !recov_done && !wr_ok) |=> bus_off);
endmodule

// File: tb/can_fault_confine_tb.sv
// Scoreboard bench: driver tasks push expected snapshots, a monitor on the
// falling edge pops them and compares against the ports.
module can_fault_confine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_pt = 1'b0, rx_bit = 1'b1;
    logic       tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0;
    logic       ifs_end = 1'b0, reset_mode = 1'b0, tec_wr_en = 1'b0;
    logic [7:0] tec_wr_data = 8'd0;
    logic       tx_in = 1'b0;
    logic       tx_out, err_flag_passive, suspend_req, bus_off;
    logic [1:0] fc_state;
    logic [8:0] tec;
    logic [7:0] rec;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        string tag;
        int    st, tc, rc;
        bit    bo, fl, su, tx;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    can_fault_confine u_dut (
        .clk(clk), .rst_n(rst_n), .sample_pt(sample_pt), .rx_bit(rx_bit),
        .tx_err(tx_err), .rx_err(rx_err), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .ifs_end(ifs_end), .reset_mode(reset_mode), .tec_wr_en(tec_wr_en),
        .tec_wr_data(tec_wr_data), .tx_in(tx_in), .tx_out(tx_out),
        .fc_state(fc_state), .tec(tec), .rec(rec),
        .err_flag_passive(err_flag_passive), .suspend_req(suspend_req),
        .bus_off(bus_off)
    );

    // Monitor: compare the oldest expected snapshot on the falling edge.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (int'(fc_state) != e.st || int'(tec) != e.tc || int'(rec) != e.rc ||
                bus_off != e.bo || err_flag_passive != e.fl ||
                suspend_req != e.su || tx_out != e.tx) begin
                errors++;
                $display("FAIL %s: actual st=%0d tec=%0d rec=%0d bo=%0d fl=%0d su=%0d tx=%0d expected st=%0d tec=%0d rec=%0d bo=%0d fl=%0d su=%0d tx=%0d",
                    e.tag, fc_state, tec, rec, bus_off, err_flag_passive, suspend_req,
                    tx_out, e.st, e.tc, e.rc, e.bo, e.fl, e.su, e.tx);
            end
        end
    end

    task automatic expect_now(string tag, int st, int tc, int rc, bit bo, bit su);
        exp_t e;
        e.tag = tag; e.st = st; e.tc = tc; e.rc = rc;
        e.bo = bo; e.fl = (st != 0); e.su = su; e.tx = tx_in | bo;
        sb.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic ev(bit te, bit re, bit tk, bit rk, bit ifs, bit smp, bit rxv);
        tx_err = te; rx_err = re; tx_ok = tk; rx_ok = rk;
        ifs_end = ifs; sample_pt = smp; rx_bit = rxv;
        @(posedge clk); #1;
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
        ifs_end = 0; sample_pt = 0; rx_bit = 1;
    endtask

    task automatic recessive(int n);
        for (int i = 0; i < n; i++) ev(0, 0, 0, 0, 0, 1, 1);
    endtask

    task automatic wr_tec(logic [7:0] d);
        tec_wr_en = 1; tec_wr_data = d;
        @(posedge clk); #1;
        tec_wr_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_now("R1 reset state", 0, 0, 0, 0, 0);

        for (int i = 0; i < 15; i++) ev(1, 0, 0, 0, 0, 0, 1);
        expect_now("R4 fifteen tx errors stay active", 0, 120, 0, 0, 0);
        ev(1, 0, 0, 0, 0, 0, 1);
        expect_now("R4 R10 sixteenth tx error passive", 1, 128, 0, 0, 0);
        ev(0, 0, 1, 0, 0, 0, 1);
        expect_now("R2 tx success decrements", 0, 127, 0, 0, 0);
        ev(1, 0, 0, 0, 0, 0, 1);
        expect_now("R2 tx error adds eight", 1, 135, 0, 0, 0);

        ev(0, 0, 0, 0, 1, 0, 1);
        expect_now("R11 suspend starts", 1, 135, 0, 0, 1);
        recessive(7);
        expect_now("R11 suspend after seven bits", 1, 135, 0, 0, 1);
        recessive(1);
        expect_now("R11 suspend ends at eight bits", 1, 135, 0, 0, 0);
        ev(0, 0, 0, 0, 1, 0, 1);
        expect_now("R11 no suspend without transmit", 1, 135, 0, 0, 0);

        for (int i = 0; i < 3; i++) ev(0, 1, 0, 0, 0, 0, 1);
        expect_now("R3 rx errors add one", 1, 135, 3, 0, 0);
        for (int i = 0; i < 4; i++) ev(0, 0, 0, 1, 0, 0, 1);
        expect_now("R3 rx success saturates at zero", 1, 135, 0, 0, 0);
        for (int i = 0; i < 2; i++) ev(0, 1, 0, 0, 0, 0, 1);

        for (int i = 0; i < 15; i++) ev(1, 0, 0, 0, 0, 0, 1);
        expect_now("R5 255 still passive", 1, 255, 2, 0, 0);
        ev(1, 0, 0, 0, 0, 0, 1);
        expect_now("R5 overflow enters bus-off", 2, 256, 2, 1, 0);
        ev(0, 1, 1, 0, 0, 0, 1);
        expect_now("R7 events ignored in bus-off", 2, 256, 2, 1, 0);

        recessive(127 * 11 + 10);
        ev(0, 0, 0, 0, 0, 1, 0);
        recessive(10);
        expect_now("R9 dominant restarts run", 2, 256, 2, 1, 0);
        recessive(1);
        expect_now("R8 R12 recovery clears counters", 0, 0, 0, 0, 0);

        wr_tec(8'd200);
        expect_now("R6 write ignored outside reset mode", 0, 0, 0, 0, 0);
        reset_mode = 1;
        ev(1, 1, 0, 0, 0, 0, 1);
        expect_now("R7 events ignored in reset mode", 0, 0, 0, 0, 0);
        wr_tec(8'd255);
        expect_now("R6 write 255 forces bus-off", 2, 255, 0, 1, 0);
        recessive(30);
        expect_now("R8 no recovery in reset mode", 2, 255, 0, 1, 0);
        wr_tec(8'd245);
        reset_mode = 0;
        expect_now("R6 write 245 gives passive", 1, 245, 0, 0, 0);

        reset_mode = 1;
        wr_tec(8'd255);
        reset_mode = 0;
        recessive(128 * 11 - 1);
        expect_now("R8 one bit short of recovery", 2, 255, 0, 1, 0);
        recessive(1);
        expect_now("R8 R12 recovery after reset mode", 0, 0, 0, 0, 0);
        tx_in = 1;
        expect_now("R12 tx follows input after recovery", 0, 0, 0, 0, 0);

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule